// File: doc/BRIEF.md
# Wait-State Bus Cycle Controller

This block is the processor-side sequencer for external bus transfers. A core hands it one request at a time: an address, write data, a direction bit and a bit that selects I/O space instead of memory space. The controller then runs a fixed sequence of phases, T1 through T4, on the external bus. It drives the address and pulses an address latch strobe, asserts a read or write strobe, and waits for the addressed device to signal that it is ready. It then finishes the transfer and hands any read data back with a one-clock completion pulse.

The length of a transfer depends on the device. The ready input is looked at only in T3. Each clock in which it is low repeats T3 as a wait state, so a slow device holds the requester for as long as it needs. Memory and I/O transfers follow the same sequence and differ only in the level of the space-select output.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset, and while idle, the latch, read, write, space-select, write-enable and done outputs are all 0, and `req_ready` is 1.
- R2: `req_ready` is 1 only in idle and in T4. A `req_valid` seen in T1, T2 or T3 is not accepted, and the bus address stays unchanged.
- R3: In T1, `bus_addr` carries the request address and `bus_ale` is 1 for exactly that one clock of each transfer.
- R4: A read asserts only `bus_rd`, and a write asserts only `bus_wr`. The strobe is 1 from T2 through the last T3, so it is high for 2 + n clocks when there are n wait states. It is 0 in T4.
- R5: `bus_ready` is sampled in T3. Each low sample adds exactly one clock, so a transfer lasts 4 + n clocks from the `bus_ale` clock to the `done` clock, counting both ends.
- R6: On a read, `bus_rdata` is captured at the clock edge that leaves the last T3. It appears on `rd_data` during the one-clock `done` pulse in T4.
- R7: On a write, `bus_wdata` carries the request data and `bus_wdata_oe` is 1 from T2 through T4. The data is valid when the device sees ready.
- R8: `bus_io` is 1 for an I/O transfer and 0 for a memory transfer. It is held from T1 through T4, and both kinds of transfer use the same phase sequence.
- R9: A request present during T4 is accepted, and its T1 follows in the very next clock, with no idle clock in between.
- R10: `bus_ready` held high outside T3 has no effect: a transfer never lasts fewer than 4 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| req_ready | output | 1 | Request can be accepted this clock |
| done | output | 1 | One-clock completion pulse in T4 |
| rd_data | output | DW | Captured read data |
| bus_addr | output | AW | External address |
| bus_ale | output | 1 | Address latch strobe (T1) |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_io | output | 1 | Space select, 1 = I/O |
| bus_wdata | output | DW | Write data to bus |
| bus_wdata_oe | output | 1 | Write data drive enable |
| bus_rdata | input | DW | Read data from bus |
| bus_ready | input | 1 | Device ready, sampled in T3 |

## Verification
The hardest state to reach from the ports is a new request arriving while a transfer is stretched by wait states. That request must be held off through every repeated T3 and then taken in T4 with no gap. The bench models a device whose wait count is set per transfer. It raises a second request in T1 of a three-wait read and keeps it asserted. It then checks that the request is refused through the waits, and that T1 follows T4 immediately with the new address. The device model returns inverted data while ready is low, so a capture taken one clock early or late shows up as wrong read data.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4
  } phase_e;

  // clocks from T1 to T4 inclusive for a given number of wait states
  function automatic int unsigned cycle_clocks(input int unsigned waits);
    return 32'd4 + waits;
  endfunction

  // phases in which the read or write strobe is active
  function automatic logic strobe_phase(input phase_e p);
    return (p == PH_T2) || (p == PH_T3);
  endfunction

  // phases in which a transfer owns the bus
  function automatic logic busy_phase(input phase_e p);
    return (p == PH_T1) || (p == PH_T2) || (p == PH_T3) || (p == PH_T4);
  endfunction

  // phases in which write data is driven
  function automatic logic data_phase(input phase_e p);
    return (p == PH_T2) || (p == PH_T3) || (p == PH_T4);
  endfunction

endpackage

// File: rtl/bcc_phase_fsm.sv
module bcc_phase_fsm
  import bcc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   ready,
  output phase_e phase,
  output logic   accept_ok,
  output logic   accept,
  output logic   t3_exit
);

  phase_e phase_q, phase_d;

  assign accept_ok = (phase_q == PH_IDLE) || (phase_q == PH_T4);
  assign accept    = start && accept_ok;
  assign t3_exit   = (phase_q == PH_T3) && ready;
  assign phase     = phase_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start) phase_d = PH_T1;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3:   if (ready) phase_d = PH_T4;
      PH_T4:   phase_d = start ? PH_T1 : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  // R4
  t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T1) |=> (phase_q == PH_T2));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T3 && !ready) |=> (phase_q == PH_T3));

  // R5
  t3_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T3 && ready) |=> (phase_q == PH_T4));

  // R9
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T4 && start) |=> (phase_q == PH_T1));

  // R2
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T2) |=> (phase_q != PH_T1));

endmodule

// File: rtl/bcc_req_hold.sv
module bcc_req_hold #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          write_in,
  input  logic          io_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          write_q,
  output logic          io_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      io_q    <= 1'b0;
    end else if (load) begin
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
      write_q <= write_in;
      io_q    <= io_in;
    end
  end

endmodule

// File: rtl/bcc_bus_drive.sv
module bcc_bus_drive
  import bcc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic          t3_exit,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] wdata_q,
  input  logic          write_q,
  input  logic          io_q,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_ale,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_io,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wdata_oe,
  output logic          done,
  output logic [DW-1:0] rd_data
);

  logic owns_bus;
  logic strobe_on;
  logic capture;

  assign owns_bus  = busy_phase(phase);
  assign strobe_on = strobe_phase(phase);
  assign capture   = t3_exit && !write_q;

  assign bus_addr     = owns_bus ? addr_q : '0;
  assign bus_io       = owns_bus && io_q;
  assign bus_ale      = (phase == PH_T1);
  assign bus_rd       = strobe_on && !write_q;
  assign bus_wr       = strobe_on && write_q;
  assign bus_wdata_oe = write_q && data_phase(phase);
  assign bus_wdata    = bus_wdata_oe ? wdata_q : '0;
  assign done         = (phase == PH_T4);

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data <= '0;
    else if (capture) rd_data <= bus_rdata;
  end

  // R4
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R3
  ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale);

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owns_bus && !bus_ale) |-> $stable(bus_addr));

  // R8
  io_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owns_bus && !bus_ale) |-> $stable(bus_io));

  // R4
  strobe_off_t4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(bus_rd || bus_wr));

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_io,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr,
  output logic          bus_ale,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_io,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wdata_oe,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready
);

  phase_e        phase;
  logic          accept;
  logic          t3_exit;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          write_q;
  logic          io_q;

  bcc_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (req_valid),
    .ready     (bus_ready),
    .phase     (phase),
    .accept_ok (req_ready),
    .accept    (accept),
    .t3_exit   (t3_exit)
  );

  bcc_req_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .write_in (req_write),
    .io_in    (req_io),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q),
    .write_q  (write_q),
    .io_q     (io_q)
  );

  bcc_bus_drive #(.AW(AW), .DW(DW)) u_drive (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase        (phase),
    .t3_exit      (t3_exit),
    .addr_q       (addr_q),
    .wdata_q      (wdata_q),
    .write_q      (write_q),
    .io_q         (io_q),
    .bus_rdata    (bus_rdata),
    .bus_addr     (bus_addr),
    .bus_ale      (bus_ale),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_io       (bus_io),
    .bus_wdata    (bus_wdata),
    .bus_wdata_oe (bus_wdata_oe),
    .done         (done),
    .rd_data      (rd_data)
  );

  // R6
  done_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_ready));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/bus_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_tb_top;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [15:0] KEY = 16'h5A3C;
  localparam int NV = 8;

  localparam logic        V_WR  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic        V_IO  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [15:0] V_ADR [NV] = '{16'h1234, 16'h0060, 16'h8000, 16'h03F8,
                                         16'hFFFF, 16'h0001, 16'h00FF, 16'h0080};
  localparam logic [15:0] V_DAT [NV] = '{16'h0000, 16'h0000, 16'hBEEF, 16'h0055,
                                         16'h0000, 16'h1357, 16'h0000, 16'hA5A5};
  localparam int          V_WS  [NV] = '{0, 1, 0, 2, 5, 1, 0, 3};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic          req_io = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, done, bus_ale, bus_rd, bus_wr, bus_io, bus_wdata_oe;
  logic [DW-1:0] rd_data, bus_wdata, bus_rdata;
  logic [AW-1:0] bus_addr;
  logic          bus_ready;

  int  n_tests = 0;
  int  n_fail  = 0;
  int  nwait   = 0;
  bit  force_ready = 1'b0;
  int  strobe_cnt = 0;
  logic [DW-1:0] dev_w = '0;

  always #2.5 clk = ~clk;

  bus_cycle_ctrl #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_io(bus_io), .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  // device model: ready after a programmable number of wait states
  always @(posedge clk) begin
    strobe_cnt <= (bus_rd || bus_wr) ? strobe_cnt + 1 : 0;
    if (bus_ready && bus_wr) dev_w <= bus_wdata;
  end
  assign bus_ready = force_ready || ((bus_rd || bus_wr) && (strobe_cnt >= 1 + nwait));
  assign bus_rdata = bus_ready ? (bus_addr ^ KEY) : ~(bus_addr ^ KEY);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_cycle(input logic w, input logic io, input logic [15:0] a,
                           input logic [15:0] d, input int nw);
    int len = 0, ale_n = 0, strb_n = 0, io_bad = 0, oe_bad = 0, dir_bad = 0;
    logic [15:0] got = '0;
    bit seen = 1'b0;
    nwait = nw;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_io = io; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_ale === 1'b1 && bus_addr === a, "R3", "T1 address", bus_addr, a);
    while (!seen && len < 1000) begin
      len++;
      if (bus_ale) ale_n++;
      if (bus_rd || bus_wr) strb_n++;
      if (w ? bus_rd : bus_wr) dir_bad++;
      if (bus_io !== io) io_bad++;
      if (w && len >= 2 && (!bus_wdata_oe || bus_wdata !== d)) oe_bad++;
      if (done) begin
        seen = 1'b1;
        got = rd_data;
      end else begin
        @(negedge clk);
      end
    end
    chk(len == 4 + nw, "R5", "cycle clocks", len, 4 + nw);
    chk(ale_n == 1, "R3", "ale clocks", ale_n, 1);
    chk(strb_n == 2 + nw && dir_bad == 0, "R4", "strobe clocks", strb_n, 2 + nw);
    chk(io_bad == 0, "R8", "space select", io_bad, 0);
    if (w) begin
      chk(oe_bad == 0, "R7", "write drive", oe_bad, 0);
      chk(dev_w == d, "R7", "device write data", dev_w, d);
    end else begin
      chk(got == (a ^ KEY), "R6", "read data", got, a ^ KEY);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!bus_ale && !bus_rd && !bus_wr && !bus_io && !done && !bus_wdata_oe,
        "R1", "strobes in reset", {bus_ale, bus_rd, bus_wr, bus_io, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "idle ready", req_ready, 1);

    for (int i = 0; i < NV; i++)
      run_cycle(V_WR[i], V_IO[i], V_ADR[i], V_DAT[i], V_WS[i]);

    // long stall
    run_cycle(1'b0, 1'b1, 16'h4242, 16'h0, 40);

    // R10: ready held high everywhere does not shorten a cycle
    force_ready = 1'b1;
    run_cycle(1'b0, 1'b0, 16'h0F0F, 16'h0, 0);
    run_cycle(1'b1, 1'b0, 16'h0F10, 16'h7788, 0);
    force_ready = 1'b0;

    // R2 / R9: request held through a stalled cycle, then taken in T4
    begin
      int guard = 0;
      nwait = 3;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_io = 1'b0; req_addr = 16'h2222;
      @(negedge clk);
      req_addr = 16'h3333;
      @(negedge clk);
      chk(req_ready === 1'b0, "R2", "ready in T2", req_ready, 0);
      @(negedge clk);
      chk(req_ready === 1'b0 && bus_addr === 16'h2222, "R2", "addr held in wait",
          bus_addr, 16'h2222);
      while (!done && guard < 100) begin guard++; @(negedge clk); end
      chk(req_ready === 1'b1, "R2", "ready in T4", req_ready, 1);
      chk(rd_data == (16'h2222 ^ KEY), "R6", "first read data", rd_data, 16'h2222 ^ KEY);
      @(negedge clk);
      req_valid = 1'b0;
      chk(bus_ale === 1'b1 && bus_addr === 16'h3333, "R9", "T1 after T4",
          bus_addr, 16'h3333);
      guard = 0;
      while (!done && guard < 100) begin guard++; @(negedge clk); end
      chk(rd_data == (16'h3333 ^ KEY), "R9", "second read data", rd_data, 16'h3333 ^ KEY);
      @(negedge clk);
      chk(!bus_ale && !bus_rd && !bus_wr && !done && req_ready, "R1", "back to idle",
          {bus_ale, bus_rd, bus_wr, done}, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule